// File: doc/BRIEF.md
# Vertical Fast-Transfer Burst Generator

This block drives the four vertical transfer phases of a CCD image sensor during the fast-readout autofocus modes. In each of these frames the vertical register is first swept quickly to dump unwanted lines at the bottom of the image. Next the upper part is shifted quickly to bring the wanted band of lines into place. Each of these fast operations is a burst. A burst is a fixed number of four-phase transfer cycles, and it has to fit inside a window made of a whole number of line periods.

A start strobe, usually tied to the line sync, launches a burst. The mode select (0 = narrow band, 1 = very narrow band) and the operation select (0 = frame shift, 1 = sweep) are sampled at that moment. Together they choose the cycle count and the window length. Within each transfer cycle, the low phase moves forward through four steps. The step lengths alternate short and long (48 and 80 clocks by default). A one-clock done pulse marks the end of the last cycle. The block then stays busy until the window closes. The clock enable qualifies every state change, so the block can be slowed to a pixel-rate enable.

Top module: `vxfer_burst`

## Requirements
- R1: After reset, vPhase is 4'b1111 (all phases high) and burstDone is 0.
- R2: A burst contains exactly the selected number of transfer cycles, counted as falling edges of V1 (vPhase bit 0): narrow-band shift 68, narrow-band sweep 75, very-narrow-band shift 110, very-narrow-band sweep 116 (parameters).
- R3: When a strobe is accepted at an enabled clock edge, V1 goes low right after that edge. The four steps of a cycle last STEP_SHORT, STEP_LONG, STEP_SHORT and STEP_LONG enabled clocks, in that order, so one cycle lasts 2*(STEP_SHORT+STEP_LONG) enabled clocks.
- R4: In vPhase, bit 0 is V1 and bit 3 is V4, and 1 means high. During a burst exactly one phase is low, so two adjacent phases are never both low. The low position moves V1, V2, V3, V4, then back to V1.
- R5: burstDone is high for exactly one clock, in the clock right after the final step ends. From that clock on, all phases are high.
- R6: From the accepting edge, the block stays busy for W = lines*LINE_CLKS enabled clocks. The line counts are: narrow-band shift 10, narrow-band sweep 11, very-narrow band 17 for either operation. Strobes that arrive while the block is busy are ignored. A strobe held high therefore restarts the burst exactly every W enabled clocks.
- R7: While clkEn is 0, no counter or phase changes, a strobe is not accepted, and burstDone stays 0.
- R8: Changes to the mode and operation selects after the accepting edge have no effect on the running burst.
- R9: When no burst is in progress, and after the final cycle, vPhase is held at 4'b1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStrobe | input | 1 | Launches a burst when the block is idle and clkEn is 1 |
| modeAf2 | input | 1 | 0 = narrow-band mode, 1 = very-narrow-band mode |
| opSweep | input | 1 | 0 = frame shift, 1 = sweep |
| clkEn | input | 1 | Clock qualifier for all state changes |
| vPhase | output | 4 | Phase levels, bit 0 = V1 … bit 3 = V4, 1 = high |
| burstDone | output | 1 | One-clock pulse after the last transfer cycle |

## Verification
A corrupted step index or step timer shows at the ports right away. The low phase moves at the wrong clock, so the per-cycle trace comparison reports it within one step length. A wrong cycle limit or a wrong latched select only shows at the end of a burst: the count of V1 falls and the position of the done pulse are both off by a whole cycle or more. A window counter error stays hidden until the next strobe. It appears as a restart that comes too early or too late, so it is checked with held and repeated strobes.

// File: rtl/vxfer_pkg.sv
package vxfer_pkg;

  typedef enum logic [1:0] {
    BST_IDLE = 2'd0,
    BST_RUN  = 2'd1,
    BST_HOLD = 2'd2
  } burstState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // latch limits, clear counters
    logic tick;      // enabled clock while busy
    logic stepWrap;  // current step finishes
    logic cycleAdv;  // a full transfer cycle finishes
    logic longStep;  // current step uses the long length
  } dpCtl_t;

  // flags from datapath to control
  typedef struct packed {
    logic stepEnd;
    logic lastCycle;
    logic winEnd;
  } dpStat_t;

endpackage

// File: rtl/vxfer_timer.sv
module vxfer_timer
  import vxfer_pkg::*;
#(
  parameter int STEP_SHORT      = 48,
  parameter int STEP_LONG       = 80,
  parameter int LINE_CLKS       = 2624,
  parameter int AF1_SHIFT_CYC   = 68,
  parameter int AF1_SWEEP_CYC   = 75,
  parameter int AF2_SHIFT_CYC   = 110,
  parameter int AF2_SWEEP_CYC   = 116,
  parameter int AF1_SHIFT_LINES = 10,
  parameter int AF1_SWEEP_LINES = 11,
  parameter int AF2_SHIFT_LINES = 17,
  parameter int AF2_SWEEP_LINES = 17
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    modeAf2,
  input  logic    opSweep,
  input  dpCtl_t  ctl,
  output dpStat_t stat
);

  localparam int MAX_STEP  = (STEP_LONG > STEP_SHORT) ? STEP_LONG : STEP_SHORT;
  localparam int STEP_W    = $clog2(MAX_STEP + 1);
  localparam int MAX_C1    = (AF1_SHIFT_CYC > AF1_SWEEP_CYC) ? AF1_SHIFT_CYC : AF1_SWEEP_CYC;
  localparam int MAX_C2    = (AF2_SHIFT_CYC > AF2_SWEEP_CYC) ? AF2_SHIFT_CYC : AF2_SWEEP_CYC;
  localparam int MAX_CYC   = (MAX_C1 > MAX_C2) ? MAX_C1 : MAX_C2;
  localparam int CYC_W     = $clog2(MAX_CYC + 1);
  localparam int MAX_L1    = (AF1_SHIFT_LINES > AF1_SWEEP_LINES) ? AF1_SHIFT_LINES : AF1_SWEEP_LINES;
  localparam int MAX_L2    = (AF2_SHIFT_LINES > AF2_SWEEP_LINES) ? AF2_SHIFT_LINES : AF2_SWEEP_LINES;
  localparam int MAX_LINES = (MAX_L1 > MAX_L2) ? MAX_L1 : MAX_L2;
  localparam int MAX_WIN   = MAX_LINES * LINE_CLKS;
  localparam int WIN_W     = $clog2(MAX_WIN + 1);

  logic [STEP_W-1:0] stepCnt;
  logic [CYC_W-1:0]  cycleCnt, cycLim, cycSel;
  logic [WIN_W-1:0]  winCnt, winLim, winSel;

  // limits picked by the selects; the window limit ends the busy span one
  // clock early so the next acceptance lands exactly W clocks later
  always_comb begin
    unique case ({modeAf2, opSweep})
      2'b00: begin
        cycSel = CYC_W'(AF1_SHIFT_CYC - 1);
        winSel = WIN_W'(AF1_SHIFT_LINES * LINE_CLKS - 2);
      end
      2'b01: begin
        cycSel = CYC_W'(AF1_SWEEP_CYC - 1);
        winSel = WIN_W'(AF1_SWEEP_LINES * LINE_CLKS - 2);
      end
      2'b10: begin
        cycSel = CYC_W'(AF2_SHIFT_CYC - 1);
        winSel = WIN_W'(AF2_SHIFT_LINES * LINE_CLKS - 2);
      end
      default: begin
        cycSel = CYC_W'(AF2_SWEEP_CYC - 1);
        winSel = WIN_W'(AF2_SWEEP_LINES * LINE_CLKS - 2);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepCnt  <= '0;
      cycleCnt <= '0;
      winCnt   <= '0;
      cycLim   <= '0;
      winLim   <= '0;
    end else if (ctl.load) begin
      stepCnt  <= '0;
      cycleCnt <= '0;
      winCnt   <= '0;
      cycLim   <= cycSel;
      winLim   <= winSel;
    end else if (ctl.tick) begin
      winCnt  <= winCnt + 1'b1;
      stepCnt <= ctl.stepWrap ? '0 : stepCnt + 1'b1;
      if (ctl.cycleAdv) cycleCnt <= cycleCnt + 1'b1;
    end
  end

  assign stat.stepEnd   = (stepCnt == (ctl.longStep ? STEP_W'(STEP_LONG - 1)
                                                    : STEP_W'(STEP_SHORT - 1)));
  assign stat.lastCycle = (cycleCnt == cycLim);
  assign stat.winEnd    = (winCnt == winLim);

endmodule

// File: rtl/vxfer_ctrl.sv
module vxfer_ctrl
  import vxfer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startStrobe,
  input  logic       clkEn,
  input  dpStat_t    stat,
  output dpCtl_t     ctl,
  output logic [3:0] vPhase,
  output logic       burstDone
);

  burstState_e state;
  logic [1:0]  stepIdx;
  logic        running, stepAdv, finish;

  assign running      = (state == BST_RUN);
  assign stepAdv      = clkEn && running && stat.stepEnd;
  assign finish       = stepAdv && (stepIdx == 2'd3) && stat.lastCycle;

  assign ctl.load     = clkEn && (state == BST_IDLE) && startStrobe;
  assign ctl.tick     = clkEn && (state != BST_IDLE);
  assign ctl.stepWrap = stepAdv;
  assign ctl.cycleAdv = stepAdv && (stepIdx == 2'd3);
  assign ctl.longStep = stepIdx[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= BST_IDLE;
      stepIdx   <= 2'd0;
      burstDone <= 1'b0;
    end else begin
      burstDone <= finish;
      if (ctl.load) begin
        state   <= BST_RUN;
        stepIdx <= 2'd0;
      end else if (ctl.tick) begin
        if (stepAdv) stepIdx <= stepIdx + 2'd1;
        if (stat.winEnd) begin
          state   <= BST_IDLE;
          stepIdx <= 2'd0;
        end else if (finish) begin
          state <= BST_HOLD;
        end
      end
    end
  end

  // one phase low at a time, low position walks upward with stepIdx
  always_comb begin
    vPhase = 4'b1111;
    if (running) vPhase = ~(4'b0001 << stepIdx);
  end

endmodule

// File: rtl/vxfer_burst.sv
module vxfer_burst
  import vxfer_pkg::*;
#(
  parameter int STEP_SHORT      = 48,
  parameter int STEP_LONG       = 80,
  parameter int LINE_CLKS       = 2624,
  parameter int AF1_SHIFT_CYC   = 68,
  parameter int AF1_SWEEP_CYC   = 75,
  parameter int AF2_SHIFT_CYC   = 110,
  parameter int AF2_SWEEP_CYC   = 116,
  parameter int AF1_SHIFT_LINES = 10,
  parameter int AF1_SWEEP_LINES = 11,
  parameter int AF2_SHIFT_LINES = 17,
  parameter int AF2_SWEEP_LINES = 17
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startStrobe,
  input  logic       modeAf2,
  input  logic       opSweep,
  input  logic       clkEn,
  output logic [3:0] vPhase,
  output logic       burstDone
);

  dpCtl_t  ctl;
  dpStat_t stat;

  vxfer_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startStrobe (startStrobe),
    .clkEn       (clkEn),
    .stat        (stat),
    .ctl         (ctl),
    .vPhase      (vPhase),
    .burstDone   (burstDone)
  );

  vxfer_timer #(
    .STEP_SHORT      (STEP_SHORT),
    .STEP_LONG       (STEP_LONG),
    .LINE_CLKS       (LINE_CLKS),
    .AF1_SHIFT_CYC   (AF1_SHIFT_CYC),
    .AF1_SWEEP_CYC   (AF1_SWEEP_CYC),
    .AF2_SHIFT_CYC   (AF2_SHIFT_CYC),
    .AF2_SWEEP_CYC   (AF2_SWEEP_CYC),
    .AF1_SHIFT_LINES (AF1_SHIFT_LINES),
    .AF1_SWEEP_LINES (AF1_SWEEP_LINES),
    .AF2_SHIFT_LINES (AF2_SHIFT_LINES),
    .AF2_SWEEP_LINES (AF2_SWEEP_LINES)
  ) u_timer (
    .clk     (clk),
    .rstN    (rstN),
    .modeAf2 (modeAf2),
    .opSweep (opSweep),
    .ctl     (ctl),
    .stat    (stat)
  );

endmodule

// File: rtl/vxfer_checker.sv
module vxfer_checker (
  input logic       clk,
  input logic       rstN,
  input logic       clkEn,
  input logic       startStrobe,
  input logic [3:0] vPhase,
  input logic       burstDone
);

  AST_MAX_ONE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $countones(vPhase) >= 3); // R4

  AST_LOW_ROTATES: assert property (@(posedge clk) disable iff (!rstN)
    (vPhase != $past(vPhase) && $past(vPhase) != 4'b1111 && vPhase != 4'b1111)
      |-> vPhase == {$past(vPhase[2:0]), $past(vPhase[3])}); // R4

  AST_BURST_OPENS_V1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(vPhase) == 4'b1111 && vPhase != 4'b1111)
      |-> (vPhase == 4'b1110 && $past(startStrobe && clkEn))); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |=> !burstDone); // R5

  AST_DONE_ALL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |-> vPhase == 4'b1111); // R5

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> ($stable(vPhase) && !burstDone)); // R7

endmodule

bind vxfer_burst vxfer_checker u_vxfer_checker (
  .clk         (clk),
  .rstN        (rstN),
  .clkEn       (clkEn),
  .startStrobe (startStrobe),
  .vPhase      (vPhase),
  .burstDone   (burstDone)
);

// File: tb/vxfer_burst_bench.sv
`timescale 1ns/1ps
module vxfer_burst_bench;

  localparam int SS  = 3;
  localparam int SL  = 5;
  localparam int LC  = 48;
  localparam int C1H = 4;
  localparam int C1W = 5;
  localparam int C2H = 6;
  localparam int C2W = 7;
  localparam int L1H = 2;
  localparam int L1W = 2;
  localparam int L2H = 3;
  localparam int L2W = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startStrobe = 1'b0;
  logic       modeAf2 = 1'b0;
  logic       opSweep = 1'b0;
  logic       clkEn = 1'b1;
  logic [3:0] vPhase;
  logic       burstDone;

  always #2 clk = ~clk;

  vxfer_burst #(
    .STEP_SHORT(SS), .STEP_LONG(SL), .LINE_CLKS(LC),
    .AF1_SHIFT_CYC(C1H), .AF1_SWEEP_CYC(C1W),
    .AF2_SHIFT_CYC(C2H), .AF2_SWEEP_CYC(C2W),
    .AF1_SHIFT_LINES(L1H), .AF1_SWEEP_LINES(L1W),
    .AF2_SHIFT_LINES(L2H), .AF2_SWEEP_LINES(L2W)
  ) u_vxfer_burst (
    .clk(clk), .rstN(rstN), .startStrobe(startStrobe), .modeAf2(modeAf2),
    .opSweep(opSweep), .clkEn(clkEn), .vPhase(vPhase), .burstDone(burstDone)
  );

  int checks = 0;
  int fails  = 0;
  string curTag = "R3 R4";

  function automatic int cycOf(input logic a2, input logic sw);
    return a2 ? (sw ? C2W : C2H) : (sw ? C1W : C1H);
  endfunction

  function automatic int winOf(input logic a2, input logic sw);
    return LC * (a2 ? (sw ? L2W : L2H) : (sw ? L1W : L1H));
  endfunction

  function automatic logic [3:0] patOf(input int k);
    int r;
    int st;
    r  = k % (2 * (SS + SL));
    st = (r < SS) ? 0 : (r < SS + SL) ? 1 : (r < 2 * SS + SL) ? 2 : 3;
    return ~(4'b0001 << st);
  endfunction

  // reference model, updated on the clock edge from the bench's own inputs
  logic mActive = 1'b0;
  int   mK = 0, mT = 0, mW = 0;
  logic mDone = 1'b0;

  function automatic logic mBusy();
    return mActive && (mK < mW - 1);
  endfunction

  always @(posedge clk) begin
    mDone = 1'b0;
    if (!rstN) begin
      mActive = 1'b0;
      mK = 0;
    end else if (clkEn) begin
      if (!mBusy() && startStrobe) begin
        mActive = 1'b1;
        mK = 0;
        mT = cycOf(modeAf2, opSweep) * 2 * (SS + SL);
        mW = winOf(modeAf2, opSweep);
      end else if (mBusy()) begin
        mK = mK + 1;
        if (mK == mT) mDone = 1'b1;
      end
    end
  end

  logic [3:0] expPh;
  logic       prevV1 = 1'b1;
  int         fallCnt = 0;
  int         doneCnt = 0;
  logic       tracing = 1'b0;

  always @(negedge clk) begin
    if (tracing) begin
      expPh = (mBusy() && mK < mT) ? patOf(mK) : 4'b1111;
      checks++;
      if (vPhase !== expPh) begin
        fails++;
        $display("FAIL %s phase got %b exp %b (k=%0d)", curTag, vPhase, expPh, mK);
      end
      checks++;
      if (burstDone !== mDone) begin
        fails++;
        $display("FAIL R5 done got %b exp %b (k=%0d)", burstDone, mDone, mK);
      end
      if (prevV1 && !vPhase[0]) fallCnt++;
      if (burstDone) doneCnt++;
      prevV1 = vPhase[0];
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0d exp %0d", tag, got, exp);
    end
  endtask

  task automatic waitIdle(input logic randEn);
    do begin
      @(negedge clk);
      if (randEn) clkEn = ($urandom % 5) != 0;
    end while (mBusy());
    clkEn = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic launch(input logic a2, input logic sw);
    @(negedge clk);
    modeAf2 = a2;
    opSweep = sw;
    startStrobe = 1'b1;
    @(negedge clk);
    startStrobe = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 phase", int'(vPhase), 15);
    check("R1 done", int'(burstDone), 0);
    tracing = 1'b1;

    // R2: each mode/op pairing, counts of cycles and done pulses
    for (int i = 0; i < 4; i++) begin
      curTag = "R3 R4 R9";
      fallCnt = 0; doneCnt = 0;
      launch(logic'(i[1]), logic'(i[0]));
      waitIdle(1'b0);
      check("R2 cycles", fallCnt, cycOf(logic'(i[1]), logic'(i[0])));
      check("R5 done count", doneCnt, 1);
    end

    // R6: strobes during burst and hold are ignored
    curTag = "R6";
    fallCnt = 0; doneCnt = 0;
    launch(1'b0, 1'b0);
    while (mBusy()) begin
      startStrobe = ($urandom % 3) == 0;
      @(negedge clk);
    end
    startStrobe = 1'b0;
    waitIdle(1'b0);
    check("R6 ignored strobes cycles", fallCnt, C1H);
    check("R6 ignored strobes done", doneCnt, 1);

    // R6: held strobe restarts every window
    fallCnt = 0; doneCnt = 0;
    @(negedge clk);
    modeAf2 = 1'b1; opSweep = 1'b1; startStrobe = 1'b1;
    repeat (2 * winOf(1'b1, 1'b1) + 5) @(negedge clk);
    startStrobe = 1'b0;
    waitIdle(1'b0);
    check("R6 held strobe bursts", doneCnt, 3);
    check("R6 held strobe cycles", fallCnt, 3 * C2W);

    // R7: strobe with clkEn low is ignored, then burst with gapped enable
    curTag = "R7";
    fallCnt = 0; doneCnt = 0;
    @(negedge clk);
    clkEn = 1'b0; startStrobe = 1'b1;
    repeat (10) @(negedge clk);
    startStrobe = 1'b0; clkEn = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 no start while disabled", fallCnt, 0);
    launch(1'b1, 1'b0);
    waitIdle(1'b1);
    check("R7 gapped cycles", fallCnt, C2H);
    check("R7 gapped done", doneCnt, 1);

    // R8: selects changed after acceptance
    curTag = "R8";
    fallCnt = 0; doneCnt = 0;
    launch(1'b0, 1'b0);
    modeAf2 = 1'b1; opSweep = 1'b1;
    waitIdle(1'b0);
    check("R8 latched selects", fallCnt, C1H);

    // random mix
    curTag = "R3 R4 R5 R6 R7";
    for (int n = 0; n < 25; n++) begin
      logic a2, sw;
      a2 = logic'($urandom % 2);
      sw = logic'($urandom % 2);
      fallCnt = 0; doneCnt = 0;
      launch(a2, sw);
      while (mBusy()) begin
        clkEn = ($urandom % 4) != 0;
        startStrobe = ($urandom % 8) == 0;
        modeAf2 = logic'($urandom % 2);
        @(negedge clk);
      end
      startStrobe = 1'b0;
      waitIdle(1'b0);
      check("R2 random cycles", fallCnt, cycOf(a2, sw));
    end

    tracing = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule